// File: doc/BRIEF.md
# Source Packet Segmenter

This block sits on the transmit side of an isochronous audio/video path. The application hands it source packets as a stream of 32-bit quadlets, framed by first and last markers. The block returns a payload stream that is cut into equal data blocks. The header builder and the bus transmitter downstream take this stream as it is. Both streams use a valid/ready handshake, so either side can stall.

Each packet can carry an optional timestamp quadlet at its front, taken from the live cycle-time input. The block then appends a configured number of zero padding quadlets. It counts the padded packet against the expected geometry, which is a power-of-two number of blocks times the block size, and marks the first quadlet of every block and of every packet. A configuration check reports padding counts that the geometry cannot hold. In header-only packing mode, the block consumes the input and emits no payload at all.

Top module: `sds_segmenter`

## Requirements
- R1: `cfg_blocks` sets the number of blocks per packet: 0 → 1, 1 → 2, 2 → 4, 3 → 8. The expected padded length is this number times the block size.
- R2: `cfg_blk_size` gives the block size in quadlets. The value 0 means 256 quadlets.
- R3: After the last input quadlet of a packet, the block emits `cfg_pad` quadlets (0 to 7) of value zero. No input is taken while they are emitted.
- R4: `cfg_err` is 1 exactly when `cfg_pad` is greater than or equal to the block size, or greater than or equal to the number of blocks per packet.
- R5: When `cfg_stamp` is 1, each packet opens with one quadlet holding `cycle_time` in bits 24:0 and zero in bits 31:25. The value is sampled in the cycle the quadlet is transferred.
- R6: `cfg_mode` values 0 (variable), 1 (fixed) and 2 (MPEG-2) give the same payload. Value 3 (header only) accepts and drops every input quadlet, emits nothing and leaves `len_err` unchanged.
- R7: When the last quadlet of each padded packet is transferred, `len_err` is set to 1 if the padded length differs from the expected length, and to 0 otherwise. It holds its value until the next packet end.
- R8: `out_pkt_start` is 1 on the first quadlet of each padded packet. `out_blk_start` is 1 on every quadlet whose index within the padded packet is a multiple of the block size.
- R9: `out_valid` stays 1 until the quadlet is accepted. `in_ready` is 0 while a timestamp or padding quadlet is offered. While input quadlets pass through, `in_ready` follows `out_ready`.
- R10: After reset, `out_valid` and `len_err` are 0.
- R11: Between packets, an input quadlet whose `in_first` is 0 is accepted and dropped without output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Packing mode |
| cfg_stamp | input | 1 | Insert timestamp quadlet |
| cfg_blocks | input | 2 | Encoded blocks per packet |
| cfg_blk_size | input | 8 | Block size in quadlets, 0 = 256 |
| cfg_pad | input | 3 | Padding quadlets per packet |
| cycle_time | input | 25 | Current cycle-time value |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Input quadlet accepted |
| in_data | input | 32 | Input quadlet |
| in_first | input | 1 | First quadlet of a source packet |
| in_last | input | 1 | Last quadlet of a source packet |
| out_valid | output | 1 | Output quadlet valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Output quadlet |
| out_blk_start | output | 1 | Quadlet opens a data block |
| out_pkt_start | output | 1 | Quadlet opens a padded packet |
| cfg_err | output | 1 | Padding count invalid for geometry |
| len_err | output | 1 | Last padded packet had wrong length |

## Verification
The bench builds the block with its default parameters: 32-bit quadlets, a 25-bit stamp, an 8-bit block-size field and a 3-bit padding field. With these values it can reach the 256-quadlet encoding of a zero size field, the full 8-block split with one-quadlet blocks, and padding right at the limits of the configuration check. A queue-based model predicts every output quadlet and its markers from the configuration. The bench compares these predictions on each clock while the output is stalled in a rolling pattern, which exercises the held-output and blocked-input rules.

// File: rtl/sds_pkg.sv
package sds_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAD} seg_st_e;
   localparam logic [1:0] PK_VAR     = 2'd0;
   localparam logic [1:0] PK_FIXED   = 2'd1;
   localparam logic [1:0] PK_MPEG    = 2'd2;
   localparam logic [1:0] PK_HDRONLY = 2'd3;
endpackage

// File: rtl/sds_geom.sv
module sds_geom #(
   parameter int DBSW = 8,
   parameter int FNW  = 2,
   parameter int QPCW = 3,
   parameter int BSW  = DBSW + 1,
   parameter int NBW  = (1 << FNW),
   parameter int TOTW = BSW + NBW
) (
   input  logic [FNW-1:0]  blocks_code,
   input  logic [DBSW-1:0] size_code,
   input  logic [QPCW-1:0] pad,
   output logic [BSW-1:0]  bsize,
   output logic [TOTW-1:0] total,
   output logic            cfg_err
);
   logic [NBW-1:0] nblk;

   generate
      if (FNW == 2) begin : g_table
         always_comb begin
            case (blocks_code)
               2'd0:    nblk = NBW'(1);
               2'd1:    nblk = NBW'(2);
               2'd2:    nblk = NBW'(4);
               default: nblk = NBW'(8);
            endcase
         end
      end else begin : g_shift
         assign nblk = NBW'(1) << blocks_code;
      end
   endgenerate

   assign bsize   = (size_code == '0) ? BSW'(1 << DBSW) : BSW'(size_code);
   assign total   = TOTW'(bsize) << blocks_code;
   assign cfg_err = (int'(pad) >= int'(bsize)) || (int'(pad) >= int'(nblk));

   initial begin
      assert (QPCW <= NBW) else $error("pad field wider than block count");
   end
endmodule

// File: rtl/sds_ctrl.sv
module sds_ctrl
   import sds_pkg::*;
#(
   parameter int QW   = 32,
   parameter int TSW  = 25,
   parameter int QPCW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stamp_en,
   input  logic            hdr_only,
   input  logic [QPCW-1:0] pad,
   input  logic [TSW-1:0]  cycle_time,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [QW-1:0]   in_data,
   input  logic            in_first,
   input  logic            in_last,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [QW-1:0]   out_data,
   output logic            out_fire,
   output logic            pkt_end
);
   seg_st_e         st, st_nx;
   logic [QPCW-1:0] pcnt;
   logic            pass, drop, stamp, last_pad, pass_last;

   always_comb begin
      drop  = (st == ST_IDLE) && (hdr_only || !in_first);
      stamp = (st == ST_IDLE) && !drop && stamp_en;
      pass  = ((st == ST_IDLE) && !drop && !stamp_en) || (st == ST_DATA);
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_data  = '0;
      if (drop) begin
         in_ready = 1'b1;
      end else if (stamp) begin
         out_valid = in_valid;
         out_data  = {{(QW-TSW){1'b0}}, cycle_time};
      end else if (pass) begin
         out_valid = in_valid;
         in_ready  = out_ready;
         out_data  = in_data;
      end else begin
         out_valid = 1'b1;
      end
   end

   assign out_fire  = out_valid && out_ready;
   assign last_pad  = (st == ST_PAD) && ((pcnt + QPCW'(1)) == pad);
   assign pass_last = pass && out_fire && in_last;
   assign pkt_end   = out_fire && ((pass_last && pad == '0) || last_pad);

   always_comb begin
      st_nx = st;
      if (out_fire) begin
         if (stamp)                 st_nx = ST_DATA;
         else if (pass && in_last)  st_nx = (pad != '0) ? ST_PAD : ST_IDLE;
         else if (pass)             st_nx = ST_DATA;
         else if (last_pad)         st_nx = ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         pcnt <= '0;
      end else begin
         st <= st_nx;
         if (st != ST_PAD)  pcnt <= '0;
         else if (out_fire) pcnt <= pcnt + QPCW'(1);
      end
   end

   initial begin
      assert (TSW < QW) else $error("stamp must fit in a quadlet");
   end

   AST_PAD_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAD) |-> !in_ready); // R9
   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid); // R9
   AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && hdr_only) |-> !out_valid); // R6
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_PAD) && out_valid) |-> (out_data == '0)); // R3
endmodule

// File: rtl/sds_pos.sv
module sds_pos #(
   parameter int BSW  = 9,
   parameter int TOTW = 13,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            out_fire,
   input  logic            pkt_end,
   input  logic [BSW-1:0]  bsize,
   input  logic [TOTW-1:0] total,
   output logic            blk_start,
   output logic            pkt_start,
   output logic            len_err
);
   logic [CNTW-1:0] qcnt;
   logic [BSW-1:0]  bcnt;

   assign blk_start = (bcnt == '0);
   assign pkt_start = (qcnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qcnt    <= '0;
         bcnt    <= '0;
         len_err <= 1'b0;
      end else if (out_fire) begin
         if (pkt_end) begin
            qcnt    <= '0;
            bcnt    <= '0;
            len_err <= (int'(qcnt) + 1) != int'(total);
         end else begin
            qcnt <= qcnt + CNTW'(1);
            bcnt <= ((bcnt + BSW'(1)) == bsize) ? '0 : bcnt + BSW'(1);
         end
      end
   end

   initial begin
      assert (CNTW > TOTW) else $error("packet counter too narrow");
   end

   AST_PKT_IS_BLK: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> blk_start); // R8
   AST_BCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt < bsize); // R2
   AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_fire && pkt_end) |=> $stable(len_err)); // R7
endmodule

// File: rtl/sds_segmenter.sv
module sds_segmenter
   import sds_pkg::*;
#(
   parameter int QW   = 32,
   parameter int TSW  = 25,
   parameter int DBSW = 8,
   parameter int FNW  = 2,
   parameter int QPCW = 3,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_mode,
   input  logic            cfg_stamp,
   input  logic [FNW-1:0]  cfg_blocks,
   input  logic [DBSW-1:0] cfg_blk_size,
   input  logic [QPCW-1:0] cfg_pad,
   input  logic [TSW-1:0]  cycle_time,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [QW-1:0]   in_data,
   input  logic            in_first,
   input  logic            in_last,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [QW-1:0]   out_data,
   output logic            out_blk_start,
   output logic            out_pkt_start,
   output logic            cfg_err,
   output logic            len_err
);
   localparam int BSW  = DBSW + 1;
   localparam int NBW  = 1 << FNW;
   localparam int TOTW = BSW + NBW;

   logic [BSW-1:0]  bsize;
   logic [TOTW-1:0] total;
   logic            out_fire, pkt_end;

   sds_geom #(.DBSW(DBSW), .FNW(FNW), .QPCW(QPCW), .BSW(BSW), .NBW(NBW), .TOTW(TOTW)) u_geom (
      .blocks_code(cfg_blocks), .size_code(cfg_blk_size), .pad(cfg_pad),
      .bsize(bsize), .total(total), .cfg_err(cfg_err));

   sds_ctrl #(.QW(QW), .TSW(TSW), .QPCW(QPCW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .stamp_en(cfg_stamp),
      .hdr_only(cfg_mode == PK_HDRONLY), .pad(cfg_pad), .cycle_time(cycle_time),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_fire(out_fire),
      .pkt_end(pkt_end));

   sds_pos #(.BSW(BSW), .TOTW(TOTW), .CNTW(CNTW)) u_pos (
      .clk(clk), .rst_n(rst_n), .out_fire(out_fire), .pkt_end(pkt_end),
      .bsize(bsize), .total(total), .blk_start(out_blk_start),
      .pkt_start(out_pkt_start), .len_err(len_err));
endmodule

// File: tb/sds_segmenter_tb.sv
module sds_segmenter_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_stamp = 1'b0;
   logic [1:0]  cfg_blocks = 2'd0;
   logic [7:0]  cfg_blk_size = 8'd1;
   logic [2:0]  cfg_pad = 3'd0;
   logic [24:0] cycle_time = '0;
   logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_ready = 1'b1;
   logic        in_ready, out_valid, out_blk_start, out_pkt_start, cfg_err, len_err;
   logic [31:0] out_data;

   sds_segmenter u_dut (.*);

   int n_chk = 0, n_fail = 0;
   logic [33:0] expq[$];
   string       tagq[$];
   logic        in_acc = 0, out_acc = 0;
   logic [33:0] out_cap = '0;
   bit          stall_en = 0, hold_ready = 0, done = 0;
   int          cyc = 0;

   always @(posedge clk) begin
      in_acc  <= in_valid && in_ready;
      out_acc <= out_valid && out_ready;
      out_cap <= {out_pkt_start, out_blk_start, out_data};
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      out_ready <= hold_ready ? 1'b0 : (stall_en ? (cyc % 3 != 0) : 1'b1);
      if (rst_n && out_acc) begin
         if (expq.size() == 0) begin
            check(0, "R6", "unexpected output quadlet", out_cap[31:0], 0);
         end else begin
            logic [33:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(out_cap[31:0] == e[31:0], t, "data", out_cap[31:0], e[31:0]);
            check(out_cap[33:32] == e[33:32], "R8", "pkt/blk markers", out_cap[33:32], e[33:32]);
         end
      end
   end

   function automatic int bsz();
      return (cfg_blk_size == 0) ? 256 : int'(cfg_blk_size);
   endfunction

   function automatic logic [31:0] dval(int i, logic [31:0] base);
      return base + 32'(i) * 32'h0101_0103;
   endfunction

   // model: returns expected len_err
   function automatic bit model_pkt(int n, logic [31:0] base, string tag);
      int idx = 0;
      if (cfg_mode == 2'd3) return 1'b0;
      if (cfg_stamp) begin
         expq.push_back({idx == 0, (idx % bsz()) == 0, 7'b0, cycle_time}); tagq.push_back("R5"); idx++;
      end
      for (int i = 0; i < n; i++) begin
         expq.push_back({idx == 0, (idx % bsz()) == 0, dval(i, base)}); tagq.push_back(tag); idx++;
      end
      for (int i = 0; i < int'(cfg_pad); i++) begin
         expq.push_back({idx == 0, (idx % bsz()) == 0, 32'h0}); tagq.push_back("R3"); idx++;
      end
      return idx != ((1 << cfg_blocks) * bsz());
   endfunction

   task automatic put(logic [31:0] d, bit f, bit l);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
      do @(negedge clk); while (!in_acc);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
   endtask

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_pkt(int n, logic [31:0] base, string tag, string lreq);
      bit le;
      le = model_pkt(n, base, tag);
      for (int i = 0; i < n; i++) put(dval(i, base), i == 0, i == n - 1);
      drain();
      check(len_err == le, lreq, "len_err", len_err, le);
   endtask

   task automatic cfg_chk(logic [1:0] fn, logic [7:0] dbs, logic [2:0] qpc, bit exp);
      @(negedge clk);
      cfg_blocks = fn; cfg_blk_size = dbs; cfg_pad = qpc;
      #1;
      check(cfg_err == exp, "R4", "cfg_err", cfg_err, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      check(len_err == 1'b0, "R10", "len_err in reset", len_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

      // R4 configuration check
      cfg_chk(2'd1, 8'd2, 3'd1, 0);
      cfg_chk(2'd1, 8'd2, 3'd2, 1);
      cfg_chk(2'd0, 8'd4, 3'd1, 1);
      cfg_chk(2'd3, 8'd0, 3'd7, 0);
      cfg_chk(2'd3, 8'd7, 3'd7, 1);
      cfg_chk(2'd0, 8'd5, 3'd0, 0);

      // R5/R9: stamp offered while stalled, input held off
      cfg_blocks = 2'd1; cfg_blk_size = 8'd3; cfg_pad = 3'd1; cfg_stamp = 1'b1;
      cycle_time = 25'h1AB_CDEF;
      hold_ready = 1;
      repeat (2) @(negedge clk);
      begin
         bit le;
         le = model_pkt(4, 32'h1000_0000, "R9");
         in_valid = 1'b1; in_data = dval(0, 32'h1000_0000); in_first = 1'b1; in_last = 1'b0;
         repeat (3) @(negedge clk);
         check(out_valid == 1'b1, "R9", "stamp valid under stall", out_valid, 1);
         check(in_ready == 1'b0, "R9", "input blocked during stamp", in_ready, 0);
         check(out_data == {7'b0, cycle_time}, "R5", "stamp quadlet", out_data, {7'b0, cycle_time});
         hold_ready = 0;
         do @(negedge clk); while (!in_acc);
         in_valid = 1'b0; in_first = 1'b0;
         for (int i = 1; i < 4; i++) put(dval(i, 32'h1000_0000), 0, i == 3);
         drain();
         check(len_err == le, "R7", "len_err after stamped packet", len_err, le);
      end

      // R11: stray quadlet between packets dropped
      cfg_stamp = 1'b0; cfg_blocks = 2'd2; cfg_blk_size = 8'd2; cfg_pad = 3'd0;
      put(32'hDEAD_BEEF, 0, 0);
      repeat (3) @(negedge clk);
      check(expq.size() == 0 && !out_valid, "R11", "stray quadlet produced output", out_valid, 0);

      // 4 blocks of 2 with a stalling consumer
      stall_en = 1;
      run_pkt(8, 32'h2000_0000, "R9", "R7");

      // R7 length mismatch, then cleared
      cfg_blocks = 2'd0; cfg_blk_size = 8'd4;
      run_pkt(3, 32'h3000_0000, "R7", "R7");
      run_pkt(4, 32'h3100_0000, "R7", "R7");

      // R2: zero size field = 256 quadlets
      stall_en = 0;
      cfg_blk_size = 8'd0;
      run_pkt(256, 32'h4000_0000, "R2", "R2");

      // R1: 8 blocks of one quadlet, fixed mode
      cfg_mode = 2'd1; cfg_blocks = 2'd3; cfg_blk_size = 8'd1;
      run_pkt(8, 32'h5000_0000, "R1", "R1");

      // R6: MPEG-2 mode, stamp + padding
      cfg_mode = 2'd2; cfg_blocks = 2'd1; cfg_blk_size = 8'd4; cfg_pad = 3'd1; cfg_stamp = 1'b1;
      cycle_time = 25'h0F0_0F0F;
      run_pkt(6, 32'h6000_0000, "R6", "R6");

      // R6: header only consumes silently, len_err untouched
      cfg_mode = 2'd3; cfg_blocks = 2'd0; cfg_blk_size = 8'd9;
      run_pkt(5, 32'h7000_0000, "R6", "R6");
      check(!out_valid, "R6", "header-only output", out_valid, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule